// File: doc/BRIEF.md
# Event-Driven Counter Run Control

This block decides, cycle by cycle, whether a timer counter advances, pauses or is frozen, according to a bank of event pulses and three per-event selection masks. A *halt* mask names events that freeze a counter half and shut off all of its later event handling until software releases it. A *stop* mask names events that pause counting while event handling stays live. A *start* mask names events that resume a paused counter. Software reaches the three masks and a control register through a small register port, with separate write lanes for the low and high 16-bit halves.

A unify input selects the counter shape. With unify set, one 32-bit counter is governed by the low-half fields only. With unify clear, the low and high halves are two independent 16-bit counters, each with its own run state and its own mask fields. The block drives a count-enable and an event-enable per half, plus the modelled counter value, which holds or increments by one.

Register select codes: 0 = halt mask, 1 = stop mask, 2 = start mask, 3 = control. In each mask register, bit n of bits 7:0 selects event n for the low half and bit 16+n selects event n for the high half. All other bits are reserved and read as zero. In the control register, bit 0 is the low stop flag, bit 1 the low halt flag, bit 16 the high stop flag and bit 17 the high halt flag.

Top module: `evt_run_ctrl`

## Requirements
- R1: After reset all three masks read zero, both halt flags read 1, both stop flags read 0, the count is zero and all four enable outputs are 0.
- R2: A write with lane bit 0 set updates only mask bits 7:0, with lane bit 1 set only bits 23:16, with both set both fields. Reserved mask bits always read 0, and the read data reflects the selected register combinationally.
- R3: When a non-halted half sees an event whose halt-mask bit is set, its halt flag is 1 after that edge, and its count-enable and event-enable are 0 from the next cycle on.
- R4: A set halt flag is cleared only by a control write to that half. Events arriving while halted change neither flag.
- R5: An event selected in the stop mask of a running, non-halted half sets its stop flag. Its count-enable drops the next cycle, its event-enable stays 1 and its count holds.
- R6: An event selected in the start mask of a stopped, non-halted half clears its stop flag, so counting resumes the next cycle.
- R7: In one cycle, a halt-selected event takes priority over stop- and start-selected events, and a stop-selected event takes priority over a start-selected one.
- R8: A control write sets both flags of each half whose lane is enabled from the write data, and it overrides any events in the same cycle.
- R9: With unify set, the high-half masks, high control lane and high state have no effect. Both enable pairs follow the low half, and the count is one 32-bit value carrying from bit 15 into bit 16.
- R10: With unify clear, each half follows only its own masks and control lane, and each 16-bit half wraps on its own with no carry between them.
- R11: Each counter half increments by one on a clock edge when its count-enable is 1, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| unify_i | input | 1 | 1: one 32-bit counter; 0: two 16-bit halves |
| evt_i | input | NUM_EV | Single-cycle event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 halt, 1 stop, 2 start, 3 control) |
| reg_lane_i | input | 2 | Write lanes: bit 0 low half, bit 1 high half |
| reg_wdata_i | input | 2*HALF_W | Write data |
| reg_rdata_o | output | 2*HALF_W | Read data of the selected register |
| cnt_en_lo_o | output | 1 | Low half (or unified) count-enable |
| cnt_en_hi_o | output | 1 | High half count-enable |
| evt_en_lo_o | output | 1 | Low half event-enable |
| evt_en_hi_o | output | 1 | High half event-enable |
| count_o | output | 2*HALF_W | Modelled counter value |

## Verification
On every cycle, the assertions check the local state transitions of each half: a halt-selected event sets the halt flag, the halt flag stays put without a control write, stop and start events move the stop flag, and control writes load both flags. They also check the counter's hold, increment and carry rules. Only the bench's scenarios can show the end-to-end ordering of priorities across mixed event patterns, lane-masked register behaviour with reserved bits, and the switch between unified and split shapes, including a full 16-bit wrap without carry and the carry into the upper half in unified mode.

// File: rtl/evt_run_pkg.sv
package evt_run_pkg;

   // register select codes
   localparam logic [1:0] SEL_HALT  = 2'd0;
   localparam logic [1:0] SEL_STOP  = 2'd1;
   localparam logic [1:0] SEL_START = 2'd2;
   localparam logic [1:0] SEL_CTRL  = 2'd3;

   localparam int NUM_MASKS = 3;

   // flag positions inside each half of the control register
   localparam int CTRL_STOP_BIT = 0;
   localparam int CTRL_HALT_BIT = 1;

endpackage

// File: rtl/evt_mask_regs.sv
module evt_mask_regs
   import evt_run_pkg::*;
#(
   parameter int NUM_EV = 8,
   parameter int HALF_W = 16
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    wr_i,
   input  logic [1:0]              sel_i,
   input  logic [1:0]              lane_i,
   input  logic [1:0][NUM_EV-1:0]  wfield_i,
   output logic [1:0][NUM_EV-1:0]  halt_msk_o,
   output logic [1:0][NUM_EV-1:0]  stop_msk_o,
   output logic [1:0][NUM_EV-1:0]  start_msk_o,
   output logic [2*HALF_W-1:0]     rdata_o
);

   logic [NUM_MASKS-1:0][1:0][NUM_EV-1:0] msk_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         msk_q <= '0;
      end else if (wr_i) begin
         for (int m = 0; m < NUM_MASKS; m++) begin
            for (int h = 0; h < 2; h++) begin
               if (sel_i == 2'(m) && lane_i[h]) begin
                  msk_q[m][h] <= wfield_i[h];
               end
            end
         end
      end
   end

   assign halt_msk_o  = msk_q[0];
   assign stop_msk_o  = msk_q[1];
   assign start_msk_o = msk_q[2];

   always_comb begin
      rdata_o = '0;
      for (int h = 0; h < 2; h++) begin
         case (sel_i)
            SEL_HALT:  rdata_o[h*HALF_W +: NUM_EV] = msk_q[0][h];
            SEL_STOP:  rdata_o[h*HALF_W +: NUM_EV] = msk_q[1][h];
            SEL_START: rdata_o[h*HALF_W +: NUM_EV] = msk_q[2][h];
            default:   rdata_o[h*HALF_W +: NUM_EV] = '0;
         endcase
      end
   end

   // a lane left out of a write keeps its field
   p_lane_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && sel_i == SEL_HALT && !lane_i[1]) |=> $stable(msk_q[0][1]));

endmodule

// File: rtl/evt_half_ctrl.sv
module evt_half_ctrl #(
   parameter int   NUM_EV       = 8,
   parameter logic RESET_HALTED = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              upd_en_i,
   input  logic              sw_wr_i,
   input  logic              sw_stop_i,
   input  logic              sw_halt_i,
   input  logic [NUM_EV-1:0] evt_i,
   input  logic [NUM_EV-1:0] halt_msk_i,
   input  logic [NUM_EV-1:0] stop_msk_i,
   input  logic [NUM_EV-1:0] start_msk_i,
   output logic              halted_o,
   output logic              stopped_o
);

   logic halted_q, stopped_q, halted_d, stopped_d;
   logic hit_halt, hit_stop, hit_start;

   assign hit_halt  = |(evt_i & halt_msk_i);
   assign hit_stop  = |(evt_i & stop_msk_i);
   assign hit_start = |(evt_i & start_msk_i);

   always_comb begin
      halted_d  = halted_q;
      stopped_d = stopped_q;
      if (sw_wr_i) begin
         halted_d  = sw_halt_i;
         stopped_d = sw_stop_i;
      end else if (upd_en_i && !halted_q) begin
         if (hit_halt) begin
            halted_d = 1'b1;
         end else if (hit_stop) begin
            stopped_d = 1'b1;
         end else if (hit_start) begin
            stopped_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         halted_q  <= RESET_HALTED;
         stopped_q <= 1'b0;
      end else begin
         halted_q  <= halted_d;
         stopped_q <= stopped_d;
      end
   end

   assign halted_o  = halted_q;
   assign stopped_o = stopped_q;

   p_halt_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_en_i && !sw_wr_i && !halted_q && hit_halt) |=> halted_q);

   p_halt_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_q && !sw_wr_i) |=> (halted_q && $stable(stopped_q)));

   p_stop_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_en_i && !sw_wr_i && !halted_q && !hit_halt && hit_stop)
      |=> (stopped_q && !halted_q));

   p_start_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_en_i && !sw_wr_i && !halted_q && stopped_q && !hit_halt && !hit_stop && hit_start)
      |=> !stopped_q);

   p_sw_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_wr_i |=> (halted_q == $past(sw_halt_i) && stopped_q == $past(sw_stop_i)));

   p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!upd_en_i && !sw_wr_i) |=> ($stable(halted_q) && $stable(stopped_q)));

endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
   parameter int HALF_W = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                unify_i,
   input  logic                en_lo_i,
   input  logic                en_hi_i,
   output logic [2*HALF_W-1:0] count_o
);

   logic [HALF_W-1:0] lo_q, hi_q;
   logic              lo_full, hi_inc;

   assign lo_full = &lo_q;
   assign hi_inc  = unify_i ? (en_lo_i && lo_full) : en_hi_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= lo_q + {{(HALF_W-1){1'b0}}, en_lo_i};
         hi_q <= hi_q + {{(HALF_W-1){1'b0}}, hi_inc};
      end
   end

   assign count_o = {hi_q, lo_q};

   p_lo_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_lo_i |=> (lo_q == $past(lo_q)));

   p_lo_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_lo_i |=> (lo_q == $past(lo_q) + 1'b1));

   p_hi_split_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!unify_i && !en_hi_i) |=> $stable(hi_q));

   p_hi_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (unify_i && en_lo_i && lo_full) |=> (hi_q == $past(hi_q) + 1'b1));

endmodule

// File: rtl/evt_run_ctrl.sv
module evt_run_ctrl
   import evt_run_pkg::*;
#(
   parameter int NUM_EV = 8,
   parameter int HALF_W = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                unify_i,
   input  logic [NUM_EV-1:0]   evt_i,
   input  logic                reg_wr_i,
   input  logic [1:0]          reg_sel_i,
   input  logic [1:0]          reg_lane_i,
   input  logic [2*HALF_W-1:0] reg_wdata_i,
   output logic [2*HALF_W-1:0] reg_rdata_o,
   output logic                cnt_en_lo_o,
   output logic                cnt_en_hi_o,
   output logic                evt_en_lo_o,
   output logic                evt_en_hi_o,
   output logic [2*HALF_W-1:0] count_o
);

   localparam int REG_W = 2 * HALF_W;

   if (NUM_EV < 1 || NUM_EV > HALF_W) begin : g_bad_num_ev
      $error("NUM_EV must lie between 1 and HALF_W");
   end
   if (HALF_W < CTRL_HALT_BIT + 1) begin : g_bad_half_w
      $error("HALF_W too small for control flags");
   end

   logic [1:0][NUM_EV-1:0] wfield, halt_msk, stop_msk, start_msk;
   logic [REG_W-1:0]       msk_rdata, ctrl_rdata;
   logic [1:0]             halted, stopped, active, sw_wr, en_own;
   logic                   ctrl_wr;
   logic                   unused_wdata;

   assign ctrl_wr      = reg_wr_i && (reg_sel_i == SEL_CTRL);
   assign unused_wdata = ^reg_wdata_i;

   evt_mask_regs #(.NUM_EV(NUM_EV), .HALF_W(HALF_W)) u_masks (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (reg_wr_i),
      .sel_i       (reg_sel_i),
      .lane_i      (reg_lane_i),
      .wfield_i    (wfield),
      .halt_msk_o  (halt_msk),
      .stop_msk_o  (stop_msk),
      .start_msk_o (start_msk),
      .rdata_o     (msk_rdata)
   );

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign wfield[h] = reg_wdata_i[h*HALF_W +: NUM_EV];

      if (h == 0) begin : g_lo
         assign active[h] = 1'b1;
      end else begin : g_hi
         assign active[h] = !unify_i;
      end

      assign sw_wr[h] = ctrl_wr && reg_lane_i[h] && active[h];

      evt_half_ctrl #(.NUM_EV(NUM_EV), .RESET_HALTED(1'b1)) u_ctrl (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .upd_en_i    (active[h]),
         .sw_wr_i     (sw_wr[h]),
         .sw_stop_i   (reg_wdata_i[h*HALF_W + CTRL_STOP_BIT]),
         .sw_halt_i   (reg_wdata_i[h*HALF_W + CTRL_HALT_BIT]),
         .evt_i       (evt_i),
         .halt_msk_i  (halt_msk[h]),
         .stop_msk_i  (stop_msk[h]),
         .start_msk_i (start_msk[h]),
         .halted_o    (halted[h]),
         .stopped_o   (stopped[h])
      );

      assign en_own[h] = !halted[h] && !stopped[h];

      always_comb begin
         ctrl_rdata[h*HALF_W +: HALF_W] = '0;
         ctrl_rdata[h*HALF_W + CTRL_STOP_BIT] = stopped[h];
         ctrl_rdata[h*HALF_W + CTRL_HALT_BIT] = halted[h];
      end
   end

   assign cnt_en_lo_o = en_own[0];
   assign cnt_en_hi_o = unify_i ? en_own[0] : en_own[1];
   assign evt_en_lo_o = !halted[0];
   assign evt_en_hi_o = unify_i ? !halted[0] : !halted[1];
   assign reg_rdata_o = (reg_sel_i == SEL_CTRL) ? ctrl_rdata : msk_rdata;

   evt_counter #(.HALF_W(HALF_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .unify_i (unify_i),
      .en_lo_i (cnt_en_lo_o),
      .en_hi_i (cnt_en_hi_o),
      .count_o (count_o)
   );

   // a stopped but live half keeps handling events
   p_stop_keeps_events_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cnt_en_lo_o && !halted[0]) |-> evt_en_lo_o);

endmodule

// File: tb/evt_run_ctrl_tb_top.sv
module evt_run_ctrl_tb_top;

   localparam int NE = 8;
   localparam int HW = 16;
   localparam int NV = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        unify = 1'b0;
   logic [7:0]  evt = '0;
   logic        wr = 1'b0;
   logic [1:0]  sel = '0;
   logic [1:0]  lane = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata, count;
   logic        en_lo, en_hi, ev_lo, ev_hi;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // model state
   logic [1:0]  m_halt, m_stop;
   logic [7:0]  m_msk [3][2];
   logic [31:0] m_cnt;
   logic        m_unify;
   string       m_tag [2];

   always #10 clk = ~clk;

   evt_run_ctrl #(.NUM_EV(NE), .HALF_W(HW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .unify_i(unify), .evt_i(evt),
      .reg_wr_i(wr), .reg_sel_i(sel), .reg_lane_i(lane), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .cnt_en_lo_o(en_lo), .cnt_en_hi_o(en_hi),
      .evt_en_lo_o(ev_lo), .evt_en_hi_o(ev_hi), .count_o(count)
   );

   // {unify, wr, sel, lane, data, evt}
   localparam logic [45:0] VEC [NV] = '{
      {1'b0, 1'b1, 2'd0, 2'b11, 32'h0080_0001, 8'h00},
      {1'b0, 1'b1, 2'd1, 2'b11, 32'h0004_0002, 8'h00},
      {1'b0, 1'b1, 2'd2, 2'b11, 32'h0008_0004, 8'h00},
      {1'b0, 1'b1, 2'd3, 2'b11, 32'h0000_0000, 8'h00},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h00},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h02},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h00},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h04},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h08},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h06},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h01},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h04},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h88},
      {1'b0, 1'b1, 2'd3, 2'b01, 32'h0000_0000, 8'h06},
      {1'b0, 1'b1, 2'd3, 2'b10, 32'h0001_0000, 8'h00},
      {1'b0, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h08},
      {1'b1, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h00},
      {1'b1, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h80},
      {1'b1, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h02},
      {1'b1, 1'b0, 2'd3, 2'b00, 32'h0000_0000, 8'h04}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [1:0] s);
      logic [31:0] r = '0;
      if (s == 2'd3) begin
         r[0] = m_stop[0]; r[1] = m_halt[0]; r[16] = m_stop[1]; r[17] = m_halt[1];
      end else begin
         r[7:0] = m_msk[s][0]; r[23:16] = m_msk[s][1];
      end
      return r;
   endfunction

   task automatic compare_all();
      logic e0, e1;
      e0 = !m_halt[0] && !m_stop[0];
      e1 = m_unify ? e0 : (!m_halt[1] && !m_stop[1]);
      chk({m_tag[0], " cnt_en_lo"}, 32'(en_lo), 32'(e0));
      chk({m_tag[1], " cnt_en_hi"}, 32'(en_hi), 32'(e1));
      chk("R3 evt_en_lo", 32'(ev_lo), 32'(!m_halt[0]));
      chk("R3 evt_en_hi", 32'(ev_hi), 32'(m_unify ? !m_halt[0] : !m_halt[1]));
      chk("R11 count", count, m_cnt);
      chk("R2 read data", rdata, m_read(sel));
   endtask

   task automatic model_reset();
      m_halt = 2'b11; m_stop = 2'b00; m_cnt = '0; m_unify = 1'b0;
      m_tag[0] = "R1"; m_tag[1] = "R1";
      for (int m = 0; m < 3; m++) for (int h = 0; h < 2; h++) m_msk[m][h] = '0;
   endtask

   task automatic model_next(input logic u, input logic w, input logic [1:0] s,
                             input logic [1:0] ln, input logic [31:0] d, input logic [7:0] e);
      logic en0, en1, act, sw, hh, hs, hst;
      en0 = !m_halt[0] && !m_stop[0];
      en1 = !m_halt[1] && !m_stop[1];
      if (u) m_cnt = m_cnt + 32'(en0);
      else m_cnt = {m_cnt[31:16] + 16'(en1), m_cnt[15:0] + 16'(en0)};
      for (int h = 0; h < 2; h++) begin
         act = (h == 0) || !u;
         sw  = w && s == 2'd3 && ln[h] && act;
         hh  = |(e & m_msk[0][h]);
         hs  = |(e & m_msk[1][h]);
         hst = |(e & m_msk[2][h]);
         if (sw) begin
            m_halt[h] = d[16*h + 1]; m_stop[h] = d[16*h]; m_tag[h] = "R8 sw write";
         end else if (!act) begin
            m_tag[h] = "R9 unify frozen";
         end else if (!m_halt[h]) begin
            if (hh) begin
               m_halt[h] = 1'b1; m_tag[h] = (hs || hst) ? "R7 halt first" : "R3 halt";
            end else if (hs) begin
               m_tag[h] = hst ? "R7 stop first" : "R5 stop";
               m_stop[h] = 1'b1;
            end else if (hst && m_stop[h]) begin
               m_stop[h] = 1'b0; m_tag[h] = "R6 start";
            end else m_tag[h] = u ? "R9 unified" : "R10 split";
         end else if (e != 0) m_tag[h] = "R4 halted ignores";
      end
      if (w && s != 2'd3)
         for (int h = 0; h < 2; h++) if (ln[h]) m_msk[s][h] = d[16*h +: 8];
      m_unify = u;
   endtask

   task automatic step(input logic u, input logic w, input logic [1:0] s,
                       input logic [1:0] ln, input logic [31:0] d, input logic [7:0] e);
      @(negedge clk);
      compare_all();
      unify = u; wr = w; sel = s; lane = ln; wdata = d; evt = e;
      model_next(u, w, s, ln, d, e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; unify = 0; wr = 0; sel = 0; lane = 0; wdata = 0; evt = 0;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic u;
      do_reset();
      // R1: reset state
      for (int s = 0; s < 4; s++) begin
         sel = 2'(s); #1;
         chk("R1 reset regs", rdata, (s == 3) ? 32'h0002_0002 : 32'h0);
      end
      sel = 2'd0;
      chk("R1 reset enables", {28'h0, en_lo, en_hi, ev_lo, ev_hi}, 32'h0);
      chk("R1 reset count", count, 32'h0);

      // R2: lane-masked writes and reserved bits
      step(0, 1, 2'd1, 2'b01, 32'hFFFF_FFFF, 8'h00);
      step(0, 0, 2'd1, 2'b00, 32'h0, 8'h00);
      chk("R2 low lane only", rdata, 32'h0000_00FF);
      step(0, 1, 2'd1, 2'b10, 32'hFFFF_FFFF, 8'h00);
      step(0, 0, 2'd1, 2'b00, 32'h0, 8'h00);
      chk("R2 high lane, reserved zero", rdata, 32'h00FF_00FF);

      // table-driven scenarios (R3..R9)
      for (int i = 0; i < NV; i++)
         step(VEC[i][45], VEC[i][44], VEC[i][43:42], VEC[i][41:40], VEC[i][39:8], VEC[i][7:0]);
      step(1, 0, 2'd3, 2'b00, 32'h0, 8'h00);
      chk("R6 unified resumed", {30'h0, en_lo, en_hi}, 32'h3);

      // R10: low half wraps alone, high half stays halted
      do_reset();
      step(0, 1, 2'd3, 2'b01, 32'h0, 8'h00);
      for (int i = 0; i < 65540; i++) step(0, 0, 2'd0, 2'b00, 32'h0, 8'h00);
      step(0, 0, 2'd0, 2'b00, 32'h0, 8'h00);
      chk("R10 no carry into high half", {16'h0, count[31:16]}, 32'h0);

      // R9: unified carry from bit 15 into bit 16
      do_reset();
      step(1, 1, 2'd3, 2'b01, 32'h0, 8'h00);
      for (int i = 0; i < 65540; i++) step(1, 0, 2'd0, 2'b00, 32'h0, 8'h00);
      step(1, 0, 2'd0, 2'b00, 32'h0, 8'h00);
      chk("R9 unified carry", {16'h0, count[31:16]}, 32'h1);

      // random mix in both shapes
      do_reset();
      u = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         logic w;
         if ($urandom % 60 == 0) u = !u;
         w = ($urandom % 6 == 0);
         step(u, w, 2'($urandom), 2'($urandom), $urandom,
              8'($urandom & $urandom & $urandom));
      end
      step(u, 0, 2'd3, 2'b00, 32'h0, 8'h00);
      report();
   end

endmodule